// File: doc/BRIEF.md
# SPI Target Transfer Engine with Abortable Frames

This block is the serial side of an SPI target (slave) port. Software places one word in a transmit holding register and reads received words from a one-word receive buffer. The engine shifts words in and out under the clock driven by an external controller. It uses SPI mode 0: SCK idles low, MOSI is sampled on the rising edge and MISO changes on the falling edge. Words are eight bits wide by default and travel most significant bit first. SCK, select and MOSI are oversampled in the system clock domain through two-flop synchronizers. For this reason SCK must run well below the system clock.

Select synchronisation is a mode that software can turn on. While it is on, bits move only while the active-low select is asserted. Releasing select part-way through a word abandons that word: the MISO driver turns off at once, the partly received bits are dropped, and the held transmit word is sent again from its first bit in the next frame. While the mode is off, select is ignored. The point at which the transmit-empty flag rises also depends on this mode.

Top module: `spi_target_xfer`

## Requirements
- R1: After reset, and whenever `en` is low, the engine reports `tx_empty`=1, `rx_full`=0, `rx_ovf`=0 and `miso_oe`=0. It drops any held transmit word and any partial frame, so the next frame after re-enabling sends zeros.
- R2: Eight rising SCK edges shift MOSI in MSB first. After the eighth, `rx_data` holds the word and `rx_full` is 1. A one-cycle `rx_rd` pulse clears `rx_full`.
- R3: MISO carries the held word MSB first. Bit 7 is valid before the first rising SCK edge, and each following bit appears after a falling edge.
- R4: If no word is held when a frame starts, the frame transmits all zeros.
- R5: A `tx_wr` pulse loads `tx_data` and clears `tx_empty`. With select sync off, `tx_empty` returns to 1 at the first rising SCK edge of the word that takes the held value.
- R6: With select sync on, `tx_empty` stays 0 until the eighth rising edge of the word, and the word stays held until then.
- R7: With select sync on, `ss_n`=1 forces `miso_oe` to 0 in the same cycle, and SCK edges seen while `ss_n` is high shift nothing.
- R8: With select sync on, raising `ss_n` mid-word discards the partial receive bits and leaves `rx_full` unchanged. The next frame resends the held word from its MSB.
- R9: With select sync off, `ss_n` has no effect: frames complete with `ss_n` high and `miso_oe` stays 1.
- R10: If a word completes while `rx_full` is 1 and no read occurs in that cycle, `rx_ovf` sets and the unread word in `rx_data` is kept. `rx_ovf` stays set until an `ovf_clr` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Engine enable; low stops and clears the engine |
| sel_sync | input | 1 | Select synchronisation mode enable |
| tx_wr | input | 1 | Load pulse for the transmit holding register |
| tx_data | input | W | Word to transmit |
| tx_empty | output | 1 | Transmit holding register is free |
| rx_rd | input | 1 | Read pulse; acknowledges the receive buffer |
| rx_data | output | W | Receive buffer contents |
| rx_full | output | 1 | Receive buffer holds an unread word |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| rx_ovf | output | 1 | Sticky receive overflow flag |
| sck | input | 1 | Serial clock from the controller |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for the MISO driver |

## Verification
The bench aborts a frame after three bits and then clocks SCK while select is high. If the design kept the partial bits or shifted during that gap, the received word of the next frame would be corrupted. If it restarted from the wrong bit, the resent word would not match. It splits a word after the first bit with select sync off, and before the last bit with select sync on. A design that ties the empty flag to the wrong point therefore reads the wrong value at one of these two points. Two words arrive back to back without a read, to catch an overflow flag that fails to set or a buffer that gets overwritten. The bench also disables the engine while a word is held, to catch stale data leaking into the next frame.

// File: rtl/spi_target_xfer.sv
`timescale 1ns/1ps
module spi_target_xfer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         sel_sync,
  input  logic         tx_wr,
  input  logic [W-1:0] tx_data,
  output logic         tx_empty,
  input  logic         rx_rd,
  output logic [W-1:0] rx_data,
  output logic         rx_full,
  input  logic         ovf_clr,
  output logic         rx_ovf,
  input  logic         sck,
  input  logic         ss_n,
  input  logic         mosi,
  output logic         miso,
  output logic         miso_oe
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [2:0]    sck_p;
  logic [1:0]    ss_p, mosi_p;
  logic [CW-1:0] cnt;
  logic [W-1:0]  tx_sh, rx_sh, hold_d, rx_buf;
  logic          hold_v, full_q, ovf_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_p  <= '0;
      ss_p   <= '1;
      mosi_p <= '0;
    end else begin
      sck_p  <= {sck_p[1:0], sck};
      ss_p   <= {ss_p[0], ss_n};
      mosi_p <= {mosi_p[0], mosi};
    end

  wire gate  = en & (~sel_sync | ~ss_p[1]);
  wire rise  = gate & sck_p[1] & ~sck_p[2];
  wire fall  = gate & ~sck_p[1] & sck_p[2];
  wire abort = en & sel_sync & ss_p[1];
  wire first = (cnt == '0);
  wire done  = rise & (cnt == LAST);
  wire [W-1:0] src    = hold_v ? hold_d : '0;
  wire [W-1:0] rx_nxt = {rx_sh[W-2:0], mosi_p[1]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt    <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      hold_d <= '0;
      hold_v <= 1'b0;
      rx_buf <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else if (!en) begin
      cnt    <= '0;
      tx_sh  <= '0;
      rx_sh  <= '0;
      hold_d <= '0;
      hold_v <= 1'b0;
      rx_buf <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
    end else begin
      if (abort) begin
        cnt   <= '0;
        rx_sh <= '0;
      end else if (rise) begin
        cnt   <= done ? '0 : cnt + 1'b1;
        rx_sh <= rx_nxt;
        if (first) tx_sh <= src;
      end else if (fall && !first) begin
        tx_sh <= tx_sh << 1;
      end

      if (tx_wr) begin
        hold_d <= tx_data;
        hold_v <= 1'b1;
      end else if (rise && (sel_sync ? done : first)) begin
        hold_v <= 1'b0;
      end

      if (ovf_clr) ovf_q <= 1'b0;
      if (done) begin
        full_q <= 1'b1;
        if (full_q && !rx_rd) ovf_q <= 1'b1;
        else rx_buf <= rx_nxt;
      end else if (rx_rd) begin
        full_q <= 1'b0;
      end
    end

  assign tx_empty = ~hold_v;
  assign rx_data  = rx_buf;
  assign rx_full  = full_q;
  assign rx_ovf   = ovf_q;
  assign miso     = first ? src[W-1] : tx_sh[W-1];
  assign miso_oe  = en & (~sel_sync | ~ss_n);
endmodule

// File: rtl/spi_target_xfer_chk.sv
`timescale 1ns/1ps
module spi_target_xfer_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         sel_sync,
  input logic         tx_wr,
  input logic         tx_empty,
  input logic         rx_rd,
  input logic [W-1:0] rx_data,
  input logic         rx_full,
  input logic         ovf_clr,
  input logic         rx_ovf,
  input logic         ss_n,
  input logic         miso_oe
);
  assert_disabled_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (tx_empty && !rx_full && !rx_ovf));

  assert_write_fills_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tx_wr) |=> !tx_empty);

  assert_released_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_sync && ss_n) |-> !miso_oe);

  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_ovf && !ovf_clr) |=> rx_ovf);

  assert_ovf_needs_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovf) |-> $past(rx_full));

  assert_unread_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rx_full && !rx_rd) |=> (rx_full && $stable(rx_data)));
endmodule

bind spi_target_xfer spi_target_xfer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .sel_sync(sel_sync), .tx_wr(tx_wr),
  .tx_empty(tx_empty), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
  .ovf_clr(ovf_clr), .rx_ovf(rx_ovf), .ss_n(ss_n), .miso_oe(miso_oe)
);

// File: tb/test_spi_target_xfer.sv
`timescale 1ns/1ps
module test_spi_target_xfer;
  logic clk = 0, rst_n = 0, en = 0, sel_sync = 0, tx_wr = 0, rx_rd = 0, ovf_clr = 0;
  logic sck = 0, ss_n = 1, mosi = 0;
  logic [7:0] tx_data = '0;
  logic [7:0] rx_data, cap;
  logic tx_empty, rx_full, rx_ovf, miso, miso_oe;
  int nchk = 0, nerr = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  spi_target_xfer #(.W(8)) i_spi_target_xfer (
    .clk(clk), .rst_n(rst_n), .en(en), .sel_sync(sel_sync), .tx_wr(tx_wr),
    .tx_data(tx_data), .tx_empty(tx_empty), .rx_rd(rx_rd), .rx_data(rx_data),
    .rx_full(rx_full), .ovf_clr(ovf_clr), .rx_ovf(rx_ovf), .sck(sck),
    .ss_n(ss_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
  );

  // {sel_sync, word to send, word on MOSI}
  localparam logic [16:0] VEC [6] = '{
    17'h1A53C, 17'h0F00F, 17'h18001, 17'h001FE, 17'h1FF00, 17'h06699
  };

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic shift_bits(input logic [7:0] d, input int n);
    for (int i = 0; i < n; i++) begin
      mosi = d[7-i];
      tick(4);
      cap = {cap[6:0], miso};
      sck = 1;
      tick(8);
      sck = 0;
      tick(4);
    end
  endtask

  task automatic load(input logic [7:0] d);
    tx_data = d; tx_wr = 1; tick(1); tx_wr = 0; tick(1);
  endtask

  task automatic read_rx();
    rx_rd = 1; tick(1); rx_rd = 0; tick(1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    cap = '0;
    tick(3);
    rst_n = 1;
    tick(2);
    check("R1 reset tx_empty", 32'(tx_empty), 1);
    check("R1 reset rx_full", 32'(rx_full), 0);
    check("R1 reset rx_ovf", 32'(rx_ovf), 0);
    check("R1 reset miso_oe", 32'(miso_oe), 0);
    en = 1;
    tick(2);

    foreach (VEC[k]) begin
      sel_sync = VEC[k][16];
      tick(2);
      load(VEC[k][15:8]);
      ss_n = sel_sync ? 1'b0 : 1'b1;
      tick(8);
      if (!VEC[k][16]) check("R9 oe with select high", 32'(miso_oe), 1);
      shift_bits(VEC[k][7:0], 8);
      check("R3 miso word", 32'(cap), 32'(VEC[k][15:8]));
      check("R2 rx_full set", 32'(rx_full), 1);
      check("R2 rx_data", 32'(rx_data), 32'(VEC[k][7:0]));
      ss_n = 1;
      read_rx();
      check("R2 rx_full cleared by read", 32'(rx_full), 0);
      tick(4);
    end

    // R4: nothing held -> zeros
    sel_sync = 1; ss_n = 0; tick(8);
    shift_bits(8'h5A, 8);
    check("R4 zeros sent", 32'(cap), 0);
    ss_n = 1; read_rx(); tick(4);

    // R5: select sync off, empty at first rising edge
    sel_sync = 0; tick(2);
    load(8'hC3);
    check("R5 write clears empty", 32'(tx_empty), 0);
    shift_bits(8'hC3, 1);
    check("R5 empty after first edge", 32'(tx_empty), 1);
    shift_bits(8'h86, 7);
    check("R5 word sent", 32'(cap), 32'hC3);
    read_rx(); tick(4);

    // R6: select sync on, empty only after the last bit
    sel_sync = 1; tick(2);
    load(8'h96);
    ss_n = 0; tick(8);
    shift_bits(8'h12, 7);
    check("R6 still held before last bit", 32'(tx_empty), 0);
    shift_bits(8'h00, 1);
    check("R6 empty after last bit", 32'(tx_empty), 1);
    check("R6 word sent", 32'(cap), 32'h96);
    ss_n = 1; read_rx(); tick(4);

    // R7 / R8: abort mid-word, clock while deselected, retry
    load(8'hA5);
    ss_n = 0; tick(8);
    shift_bits(8'hFF, 3);
    ss_n = 1; #1;
    check("R7 oe released at once", 32'(miso_oe), 0);
    tick(4);
    check("R8 no rx_full after abort", 32'(rx_full), 0);
    check("R8 word still held", 32'(tx_empty), 0);
    shift_bits(8'hC0, 2);
    check("R7 no shift while deselected", 32'(rx_full), 0);
    ss_n = 0; tick(8);
    shift_bits(8'h3C, 8);
    check("R8 resent from MSB", 32'(cap), 32'hA5);
    check("R8 clean receive after abort", 32'(rx_data), 32'h3C);
    check("R8 rx_full after full frame", 32'(rx_full), 1);
    ss_n = 1; read_rx(); tick(4);

    // R10: overflow
    sel_sync = 0; tick(2);
    shift_bits(8'h81, 8);
    shift_bits(8'h7E, 8);
    check("R10 overflow set", 32'(rx_ovf), 1);
    check("R10 unread word kept", 32'(rx_data), 32'h81);
    check("R10 still full", 32'(rx_full), 1);
    tick(6);
    check("R10 overflow sticky", 32'(rx_ovf), 1);
    ovf_clr = 1; tick(1); ovf_clr = 0; tick(1);
    check("R10 overflow cleared", 32'(rx_ovf), 0);
    read_rx(); tick(4);

    // R1: disable drops the held word
    load(8'h44);
    en = 0; tick(2);
    check("R1 disable empties", 32'(tx_empty), 1);
    check("R1 disable oe", 32'(miso_oe), 0);
    en = 1; sel_sync = 1; tick(2);
    ss_n = 0; tick(8);
    shift_bits(8'h00, 8);
    check("R1 no stale word after disable", 32'(cap), 0);
    ss_n = 1; tick(4);

    finish_run();
  end
endmodule